// File: doc/BRIEF.md
# Bitmap-Assist Banked RAM Controller

This block sits on the cartridge side of an 8-bit CPU bus that carries a 13-bit address and a data bus but no read/write strobe. It samples the address once per CPU cycle. It serves a 256-byte window at $1000-$10FF onto a 16-page display RAM. The page seen through that window is chosen as a side effect of touching any address in $1F00-$1FFF. Part of that region returns single-bit set masks and single-bit clear masks. A program can therefore load a pixel mask indexed by the X coordinate, and in the same access point the window at the matching display column. It then combines the mask with the byte indexed by the Y coordinate and stores the result back.

Because the bus has no direction line, the block infers a write when the same RAM address is presented on two consecutive cycles. The usual store sequence is a dummy read followed by the real write to the same address, so the block stores the data present in that second cycle. A lone access is treated as a read: the block drives the stored byte with its output enable raised. In a cycle it judges to be a write, it leaves the bus undriven.

A second, unbanked 256-byte scratch region sits at $1800-$18FF. Each of the two RAM regions has its own write-protect latch, set and cleared by touching fixed hotspot addresses. A protected region still answers reads, for example for code execution.

Top module: `bitmap_bank_ctrl`

## Requirements
- R1: After reset the display page is 0, both regions are unprotected, and the first RAM access is treated as a read even if its address equals the address presented during reset.
- R2: Any access to $1F00-$1FFF loads the page register with page[3] = A3 and page[2:0] = A6:A4. A7 and A2:A0 do not affect the page. The new page applies from the next cycle on.
- R3: An access to $1F00-$1F5F drives 8'h01 shifted left by A2:A0 with output enable high. An access to $1F80-$1FDF drives the bitwise inverse of that byte. The block does not drive $1F60-$1F7F or $1FE0-$1FFF.
- R4: An access to $1000-$10FF reaches display byte page*256 + A7:A0. When it is not a write per R5, the block raises output enable and drives the stored byte.
- R5: A RAM access whose 13-bit address equals that of the immediately preceding cycle, when that preceding cycle was also a RAM access, is a write. The block stores the data bus value of that cycle and holds output enable low.
- R6: On three or more consecutive accesses to one RAM address, the first is a read and every later one is a write. The byte ends up holding the data of the last access.
- R7: A cycle outside both RAM regions breaks the pairing. A window access followed by an outside access stores nothing, and so does a repeat of the same window address after an intervening cycle.
- R8: $1800-$18FF is a 256-byte scratch RAM that ignores the page register and uses the same read/write inference.
- R9: Touching $1200 protects the display RAM and $1201 unprotects it. Touching $1202 protects the scratch RAM and $1203 unprotects it (A0 = 1 clears, A1 = 1 selects scratch). A protected region drops inferred writes, still releases the bus in write cycles, and still answers reads. The two latches are independent.
- R10: For every address outside $1000-$10FF, $1800-$18FF, $1F00-$1F5F and $1F80-$1FDF, output enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One rising edge per CPU bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Cartridge address for this cycle |
| bus_din | input | 8 | Data bus value driven by the CPU |
| bus_dout | output | 8 | Data driven toward the CPU |
| bus_oe | output | 1 | High when bus_dout should be driven onto the bus |

## Verification
The bench uses the fixed geometry of 16 display pages of 256 bytes and a 256-byte scratch region. That is small enough to write and read back every display byte through the window, with the page chosen from one mask half when writing and from the other half when reading back. All 256 addresses of the $1Fxx region are swept against masks computed in the bench. The remaining sequences cover triple repeats, a store whose final access leaves the window, writes broken by an intervening cycle, and every protect and unprotect combination of the two latches.

// File: rtl/bbc_pkg.sv
`timescale 1ns/1ps
package bbc_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int PAGE_W  = 4;
  localparam int OFS_W   = 8;
  localparam int DISP_DEPTH = (1 << PAGE_W) << OFS_W;
  localparam int SCR_DEPTH  = 1 << OFS_W;
  localparam int HI_W    = ADDR_W - OFS_W;

  localparam logic [HI_W-1:0] WIN_PAGE  = 5'h10;
  localparam logic [HI_W-1:0] SCR_PAGE  = 5'h18;
  localparam logic [HI_W-1:0] MASK_PAGE = 5'h1F;
  localparam logic [ADDR_W-3:0] HOT_BASE = 11'h480; // $1200..$1203

  typedef struct packed {
    logic              win;
    logic              scr;
    logic              mask;
    logic              mask_drive;
    logic [DATA_W-1:0] mask_byte;
    logic              hot;
    logic              hot_scr;
    logic              hot_clr;
  } dec_t;
endpackage

// File: rtl/bbc_decode.sv
`timescale 1ns/1ps
module bbc_decode
  import bbc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [HI_W-1:0]   hi;
  logic [DATA_W-1:0] bitsel;

  always_comb begin
    hi     = addr[ADDR_W-1:OFS_W];
    bitsel = DATA_W'(1) << addr[2:0];
    dec.win        = (hi == WIN_PAGE);
    dec.scr        = (hi == SCR_PAGE);
    dec.mask       = (hi == MASK_PAGE);
    // low 0x60 bytes of each half carry mask bytes
    dec.mask_drive = dec.mask && (addr[6:5] != 2'b11);
    dec.mask_byte  = addr[7] ? ~bitsel : bitsel;
    dec.hot        = (addr[ADDR_W-1:2] == HOT_BASE);
    dec.hot_scr    = addr[1];
    dec.hot_clr    = addr[0];
  end
endmodule

// File: rtl/bbc_pair_track.sv
`timescale 1ns/1ps
module bbc_pair_track
  import bbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              in_ram,
  output logic              is_write
);
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;
  logic              prev_vld_q, prev_vld_d;
  logic              addr_en;

  always_comb begin
    addr_en     = in_ram;
    prev_vld_d  = in_ram;
    prev_addr_d = addr;
    is_write    = in_ram && prev_vld_q && (prev_addr_q == addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_vld_q <= prev_vld_d;
      if (addr_en) prev_addr_q <= prev_addr_d;
    end
  end
endmodule

// File: rtl/bbc_ctrl.sv
`timescale 1ns/1ps
module bbc_ctrl
  import bbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  dec_t              dec,
  output logic [PAGE_W-1:0] page,
  output logic              wp_disp,
  output logic              wp_scr
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic              wpd_q, wpd_d, wps_q, wps_d;

  always_comb begin
    page_d = page_q;
    wpd_d  = wpd_q;
    wps_d  = wps_q;
    if (dec.mask) page_d = {addr[3], addr[6:4]};
    if (dec.hot) begin
      if (dec.hot_scr) wps_d = ~dec.hot_clr;
      else             wpd_d = ~dec.hot_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      wpd_q  <= 1'b0;
      wps_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      wpd_q  <= wpd_d;
      wps_q  <= wps_d;
    end
  end

  assign page    = page_q;
  assign wp_disp = wpd_q;
  assign wp_scr  = wps_q;
endmodule

// File: rtl/bbc_ram.sv
`timescale 1ns/1ps
module bbc_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bitmap_bank_ctrl.sv
`timescale 1ns/1ps
module bitmap_bank_ctrl
  import bbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       bus_addr,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic              bus_oe
);
  localparam int DISP_AW = $clog2(DISP_DEPTH);
  localparam int SCR_AW  = $clog2(SCR_DEPTH);

  dec_t              dec;
  logic              in_ram, is_write;
  logic [PAGE_W-1:0] page;
  logic              wp_disp, wp_scr;
  logic              disp_we, scr_we;
  logic [DATA_W-1:0] disp_rd, scr_rd;
  logic [DISP_AW-1:0] disp_addr;

  bbc_decode u_dec (.addr(bus_addr), .dec(dec));

  assign in_ram = dec.win | dec.scr;

  bbc_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .in_ram(in_ram), .is_write(is_write)
  );

  bbc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .dec(dec),
    .page(page), .wp_disp(wp_disp), .wp_scr(wp_scr)
  );

  assign disp_addr = {page, bus_addr[OFS_W-1:0]};
  assign disp_we   = dec.win & is_write & ~wp_disp;
  assign scr_we    = dec.scr & is_write & ~wp_scr;

  bbc_ram #(.DEPTH(DISP_DEPTH), .WIDTH(DATA_W)) u_disp (
    .clk(clk), .we(disp_we), .addr(disp_addr),
    .wdata(bus_din), .rdata(disp_rd)
  );

  bbc_ram #(.DEPTH(SCR_DEPTH), .WIDTH(DATA_W)) u_scr (
    .clk(clk), .we(scr_we), .addr(bus_addr[SCR_AW-1:0]),
    .wdata(bus_din), .rdata(scr_rd)
  );

  always_comb begin
    bus_oe   = 1'b0;
    bus_dout = '0;
    if (dec.mask_drive) begin
      bus_oe   = 1'b1;
      bus_dout = dec.mask_byte;
    end else if (in_ram && !is_write) begin
      bus_oe   = 1'b1;
      bus_dout = dec.win ? disp_rd : scr_rd;
    end
  end
endmodule

// File: rtl/bbc_checker.sv
`timescale 1ns/1ps
module bbc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] bus_addr,
  input logic [7:0]  bus_dout,
  input logic        bus_oe,
  input logic [3:0]  page,
  input logic        wp_disp,
  input logic        wp_scr
);
  logic armed;
  logic cur_ram, cur_mask, cur_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign cur_ram   = (bus_addr[12:8] == 5'h10) || (bus_addr[12:8] == 5'h18);
  assign cur_mask  = (bus_addr[12:8] == 5'h1F);
  assign cur_drive = cur_mask && (bus_addr[6:5] != 2'b11);

  // R2
  a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(cur_mask) |-> page == {$past(bus_addr[3]), $past(bus_addr[6:4])});

  // R3
  a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cur_drive |-> bus_oe &&
      ($countones(bus_addr[7] ? ~bus_dout : bus_dout) == 1));

  // R5
  a_r5_release_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cur_ram && $past(cur_ram) && (bus_addr == $past(bus_addr)) |-> !bus_oe);

  // R9
  a_r9_protect_latch: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(bus_addr == 13'h1200) |-> wp_disp);

  a_r9_unprotect_scr: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(bus_addr == 13'h1203) |-> !wp_scr);

  // R10
  a_r10_oe_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> cur_ram || cur_drive);
endmodule

bind bitmap_bank_ctrl bbc_checker i_bbc_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
  .bus_oe(bus_oe), .page(page), .wp_disp(wp_disp), .wp_scr(wp_scr)
);

// File: tb/test_bitmap_bank_ctrl.sv
`timescale 1ns/1ps
module test_bitmap_bank_ctrl;
  logic        clk;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic [7:0]  bus_din;
  logic [7:0]  bus_dout;
  logic        bus_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic       s_oe;
  logic [7:0] s_dout;
  logic [7:0] disp_exp [4096];
  logic [7:0] scr_exp [256];

  bitmap_bank_ctrl i_bitmap_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic oe_e, input logic [7:0] d_e);
    n_cmp++;
    if (s_oe !== oe_e || (oe_e && s_dout !== d_e)) begin
      n_bad++;
      $display("FAIL %s addr=%04h: oe=%0b data=%02h expected oe=%0b data=%02h",
               req, bus_addr, s_oe, s_dout, oe_e, d_e);
    end
  endtask

  task automatic access(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_din  = d;
    #1;
    s_oe   = bus_oe;
    s_dout = bus_dout;
  endtask

  task automatic idle();
    access(13'h0000, 8'h00);
  endtask

  function automatic logic [12:0] sel_addr(input int p, input bit upper, input bit lowbits);
    logic [12:0] a;
    a = 13'h1F00;
    a[7] = upper;
    a[6:4] = 3'(p);
    a[3] = (p >= 8);
    a[2:0] = lowbits ? 3'b111 : 3'b000;
    return a;
  endfunction

  function automatic logic [7:0] pat(input int p, input int o);
    return 8'((p * 29 + o * 7 + 3) & 255);
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    access(a, 8'h00);
    access(a, d);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 13'h0000;
    bus_din = 8'h00;
    #1;
    s_oe = bus_oe; s_dout = bus_dout;
    check("R1 reset idle", 1'b0, 8'h00);
    @(negedge clk);
    bus_addr = 13'h1005;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: same address as during reset is still a read
    #1; s_oe = bus_oe; s_dout = bus_dout;
    check("R1 first access reads", 1'b1, bus_dout);
    access(13'h1005, 8'hA5);
    idle();
    disp_exp[5] = 8'hA5;
    access(sel_addr(1, 0, 0), 8'h00);
    wr(13'h1005, 8'h5A);
    disp_exp[256 + 5] = 8'h5A;
    access(sel_addr(0, 1, 1), 8'h00);
    access(13'h1005, 8'h00);
    check("R1 page resets to 0", 1'b1, 8'hA5);
    idle();

    // R3 sweep of mask region
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      logic dr;
      b  = 8'(1 << (i % 8));
      dr = ((i % 128) < 96);
      access(13'h1F00 + 13'(i), 8'h00);
      check("R3 mask byte", dr, (i >= 128) ? ~b : b);
    end

    // R2/R4/R5 exhaustive display fill through lower half selects
    for (int p = 0; p < 16; p++) begin
      access(sel_addr(p, 0, 0), 8'h00);
      for (int o = 0; o < 256; o++) begin
        access(13'h1000 + 13'(o), 8'h00);
        access(13'h1000 + 13'(o), pat(p, o));
        if (o == 0) check("R5 write releases bus", 1'b0, 8'h00);
        idle();
        disp_exp[p * 256 + o] = pat(p, o);
      end
    end
    for (int p = 0; p < 16; p++) begin
      access(sel_addr(p, 1, 1), 8'h00);
      for (int o = 0; o < 256; o++) begin
        access(13'h1000 + 13'(o), 8'h00);
        check("R2 R4 readback", 1'b1, disp_exp[p * 256 + o]);
        idle();
      end
    end

    // R6 triple repeat
    access(sel_addr(3, 0, 0), 8'h00);
    access(13'h1077, 8'h00);
    check("R6 first of run reads", 1'b1, disp_exp[3 * 256 + 8'h77]);
    access(13'h1077, 8'h11); check("R6 second writes", 1'b0, 8'h00);
    access(13'h1077, 8'h22); check("R6 third writes", 1'b0, 8'h00);
    access(13'h1077, 8'h33); check("R6 fourth writes", 1'b0, 8'h00);
    idle();
    disp_exp[3 * 256 + 8'h77] = 8'h33;
    access(13'h1077, 8'h00);
    check("R6 last value kept", 1'b1, 8'h33);
    idle();

    // R7 store carrying out of the window, and broken pairs
    access(13'h1040, 8'hEE);
    access(13'h1140, 8'hEE);
    check("R10 outside window", 1'b0, 8'h00);
    idle();
    access(13'h1040, 8'h00);
    check("R7 carry-out no store", 1'b1, disp_exp[3 * 256 + 8'h40]);
    idle();
    access(13'h1040, 8'hFF);
    check("R7 broken pair reads", 1'b1, disp_exp[3 * 256 + 8'h40]);
    idle();
    access(13'h1041, 8'h00);
    access(13'h1042, 8'h99);
    check("R7 different address reads", 1'b1, disp_exp[3 * 256 + 8'h42]);
    idle();
    access(13'h1042, 8'h00);
    check("R7 different address no store", 1'b1, disp_exp[3 * 256 + 8'h42]);
    idle();

    // R8 scratch fill and page independence
    for (int o = 0; o < 256; o++) begin
      wr(13'h1800 + 13'(o), 8'(o ^ 8'h5C));
      scr_exp[o] = 8'(o ^ 8'h5C);
    end
    access(sel_addr(9, 0, 0), 8'h00);
    for (int o = 0; o < 256; o++) begin
      access(13'h1800 + 13'(o), 8'h00);
      check("R8 scratch readback", 1'b1, scr_exp[o]);
      idle();
    end

    // R9 write protect
    access(sel_addr(3, 0, 0), 8'h00);
    access(13'h1200, 8'h00);
    access(13'h1040, 8'h00);
    access(13'h1040, 8'h12);
    check("R9 protected write releases bus", 1'b0, 8'h00);
    idle();
    access(13'h1040, 8'h00);
    check("R9 display protected", 1'b1, disp_exp[3 * 256 + 8'h40]);
    idle();
    wr(13'h1810, 8'h77); scr_exp[16] = 8'h77;
    access(13'h1810, 8'h00);
    check("R9 scratch independent", 1'b1, 8'h77);
    idle();
    access(13'h1202, 8'h00);
    wr(13'h1810, 8'h88);
    access(13'h1810, 8'h00);
    check("R9 scratch protected", 1'b1, 8'h77);
    idle();
    access(13'h1201, 8'h00);
    wr(13'h1040, 8'h12); disp_exp[3 * 256 + 8'h40] = 8'h12;
    access(13'h1040, 8'h00);
    check("R9 display unprotected", 1'b1, 8'h12);
    idle();
    wr(13'h1810, 8'h88);
    access(13'h1810, 8'h00);
    check("R9 scratch still protected", 1'b1, 8'h77);
    idle();
    access(13'h1203, 8'h00);
    wr(13'h1810, 8'h99);
    access(13'h1810, 8'h00);
    check("R9 scratch unprotected", 1'b1, 8'h99);
    idle();

    // R10 unmapped addresses
    for (int i = 0; i < 32; i++) begin
      logic [12:0] a;
      a = 13'(i * 256 + 8'h65);
      if (i != 5'h10 && i != 5'h18 && i != 5'h1F) begin
        access(a, 8'h00);
        check("R10 unmapped", 1'b0, 8'h00);
      end
    end
    access(13'h1FE3, 8'h00);
    check("R10 mask gap", 1'b0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule